// File: doc/BRIEF.md
# Single-Bus Instruction Control Sequencer

This block is the hardwired control unit of a small processor whose registers all share one data bus. On every clock it issues one control step. Each step names at most one register that drives the bus and any set of registers that load from it. It can also strobe a memory read and choose the ALU operation. The sequencer fetches an instruction, increments the program counter and hands the fetched word to the instruction register. It then looks at the decoded instruction lines from an outside decoder. On the add line it runs the execute steps of a register-plus-memory add. With any other pattern it closes the instruction and fetches again.

Both memory reads depend on a memory-complete handshake. The sequencer parks in a wait step until that input is high, and its outputs stay constant while it waits. The outputs depend only on the current step. Each of them therefore settles one clock edge after the transition that selects it.

The reset input clears asynchronously. Its release passes through a short synchronizer chain. All enables stay low until the chain has released, and the first step shown after that is the first fetch step.

Top module: `ctrl_seq`

## Requirements
- R1: While `rst_n` is low all outputs are 0. After `rst_n` rises, the outputs stay 0 through the first SYNC_STAGES rising edges (default 2). After those edges the outputs show the first fetch step.
- R2: The first fetch step drives PC onto the bus, loads MAR and Z, asserts `mem_rd` and sets `alu_op` to increment (code 2). Register index bits in both `drv_en` and `ld_en` are: 0 PC, 1 MAR, 2 MDR, 3 IR, 4 Y, 5 Z, 6 R1.
- R3: The step after the first fetch step drives Z and loads PC. The step after that is the fetch wait step.
- R4: A wait step has every enable, `mem_rd`, `alu_op` and `end_flag` at 0. The sequencer leaves a wait step on the next edge only if `mem_done` is high at that edge. Otherwise it stays in the wait step with its outputs unchanged.
- R5: After the fetch wait the next step drives MDR and loads IR. The step after that is a decode step with all outputs 0.
- R6: In the decode step, if line ADD_LINE (default bit 0) of `ins_line` is 1, the execute steps follow. Otherwise a single step with only `end_flag` high follows, R1 is left untouched, and the next step is the first fetch step.
- R7: The first execute step drives IR (its low address field), loads MAR and asserts `mem_rd`. A wait step as in R4 follows it.
- R8: After the operand wait, three steps follow. The first drives R1 and loads Y. The second drives MDR with `alu_op` add (code 1) and loads Z. The third drives Z, loads R1 and raises `end_flag`. After any step with `end_flag` high, the first fetch step follows.
- R9: At most one bit of `drv_en` is ever high. `mem_done` has no effect outside the wait steps, and `ins_line` has no effect outside the decode step.
- R10: Run against a register-transfer datapath, an add instruction leaves R1 equal to its old value plus the memory word at the address field of the fetched word, and leaves PC one higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_done | input | 1 | Memory-complete handshake |
| ins_line | input | N_INS | One-hot decoded instruction lines from the external decoder |
| drv_en | output | 7 | Bus driver enable for each register |
| ld_en | output | 7 | Load enable for each register |
| mem_rd | output | 1 | Memory read strobe |
| alu_op | output | 2 | ALU operation: 0 none, 1 add Y+bus, 2 increment bus |
| end_flag | output | 1 | End of instruction |

## Verification
Each output is a function of the step register alone. A new input therefore shows up in the outputs one edge after it is sampled, and never within the same cycle. The bench drives inputs just after a falling edge. At the next falling edge it compares the full control word with the step it expects, advancing its own step model with exactly the inputs it drove. After reset release it allows the two synchronizer edges before it expects the first fetch step. Datapath results (R1, PC) exist one edge after the write-back or end step, and the bench checks them at the falling edge that follows.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;

  localparam int NREG = 7;

  typedef enum logic [3:0] {
    ST_F_ADDR  = 4'd0,
    ST_F_INC   = 4'd1,
    ST_F_WAIT  = 4'd2,
    ST_F_IR    = 4'd3,
    ST_DEC     = 4'd4,
    ST_X_ADDR  = 4'd5,
    ST_X_WAIT  = 4'd6,
    ST_X_Y     = 4'd7,
    ST_X_SUM   = 4'd8,
    ST_X_WB    = 4'd9,
    ST_NOP_END = 4'd10
  } seq_state_e;

  typedef enum logic [2:0] {
    RG_PC  = 3'd0,
    RG_MAR = 3'd1,
    RG_MDR = 3'd2,
    RG_IR  = 3'd3,
    RG_Y   = 3'd4,
    RG_Z   = 3'd5,
    RG_R1  = 3'd6
  } reg_id_e;

  typedef enum logic [1:0] {
    ALU_NONE = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_INC  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic            drv_vld;
    reg_id_e         drv_id;
    logic [NREG-1:0] ld;
    logic            rd;
    alu_op_e         alu;
    logic            fin;
  } ctrl_word_t;

endpackage

// File: rtl/ctrl_seq_rst_sync.sv
module ctrl_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= (chain << 1) | STAGES'(1);
  end

  assign srst_n = chain[STAGES-1];

endmodule

// File: rtl/ctrl_seq_next.sv
module ctrl_seq_next
  import ctrl_seq_pkg::*;
#(
  parameter int N_INS    = 4,
  parameter int ADD_LINE = 0
) (
  input  seq_state_e       cur,
  input  logic             mem_done,
  input  logic [N_INS-1:0] ins_line,
  output seq_state_e       nxt
);

  logic any_line;
  logic take_add;

  assign any_line = |ins_line;
  assign take_add = any_line & ins_line[ADD_LINE];

  always_comb begin
    nxt = ST_F_ADDR;
    case (cur)
      ST_F_ADDR:  nxt = ST_F_INC;
      ST_F_INC:   nxt = ST_F_WAIT;
      ST_F_WAIT:  nxt = mem_done ? ST_F_IR : ST_F_WAIT;
      ST_F_IR:    nxt = ST_DEC;
      ST_DEC:     nxt = take_add ? ST_X_ADDR : ST_NOP_END;
      ST_X_ADDR:  nxt = ST_X_WAIT;
      ST_X_WAIT:  nxt = mem_done ? ST_X_Y : ST_X_WAIT;
      ST_X_Y:     nxt = ST_X_SUM;
      ST_X_SUM:   nxt = ST_X_WB;
      ST_X_WB:    nxt = ST_F_ADDR;
      ST_NOP_END: nxt = ST_F_ADDR;
      default:    nxt = ST_F_ADDR;
    endcase
  end

endmodule

// File: rtl/ctrl_seq_out.sv
module ctrl_seq_out
  import ctrl_seq_pkg::*;
(
  input  seq_state_e      cur,
  input  logic            live,
  output logic [NREG-1:0] drv_en,
  output logic [NREG-1:0] ld_en,
  output logic            mem_rd,
  output logic [1:0]      alu_op,
  output logic            end_flag
);

  ctrl_word_t w;

  function automatic logic [NREG-1:0] bit_of(reg_id_e r);
    logic [NREG-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  always_comb begin
    w = '{drv_vld: 1'b0, drv_id: RG_PC, ld: '0, rd: 1'b0, alu: ALU_NONE, fin: 1'b0};
    case (cur)
      ST_F_ADDR: begin
        w.drv_vld = 1'b1; w.drv_id = RG_PC;
        w.ld  = bit_of(RG_MAR) | bit_of(RG_Z);
        w.rd  = 1'b1;
        w.alu = ALU_INC;
      end
      ST_F_INC: begin
        w.drv_vld = 1'b1; w.drv_id = RG_Z;
        w.ld = bit_of(RG_PC);
      end
      ST_F_IR: begin
        w.drv_vld = 1'b1; w.drv_id = RG_MDR;
        w.ld = bit_of(RG_IR);
      end
      ST_X_ADDR: begin
        w.drv_vld = 1'b1; w.drv_id = RG_IR;
        w.ld = bit_of(RG_MAR);
        w.rd = 1'b1;
      end
      ST_X_Y: begin
        w.drv_vld = 1'b1; w.drv_id = RG_R1;
        w.ld = bit_of(RG_Y);
      end
      ST_X_SUM: begin
        w.drv_vld = 1'b1; w.drv_id = RG_MDR;
        w.ld  = bit_of(RG_Z);
        w.alu = ALU_ADD;
      end
      ST_X_WB: begin
        w.drv_vld = 1'b1; w.drv_id = RG_Z;
        w.ld  = bit_of(RG_R1);
        w.fin = 1'b1;
      end
      ST_NOP_END: w.fin = 1'b1;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_en
    assign drv_en[i] = live & w.drv_vld & (w.drv_id == 3'(i));
    assign ld_en[i]  = live & w.ld[i];
  end

  assign mem_rd   = live & w.rd;
  assign alu_op   = live ? w.alu : ALU_NONE;
  assign end_flag = live & w.fin;

endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_seq_pkg::*;
#(
  parameter int N_INS       = 4,
  parameter int ADD_LINE    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_done,
  input  logic [N_INS-1:0] ins_line,
  output logic [NREG-1:0]  drv_en,
  output logic [NREG-1:0]  ld_en,
  output logic             mem_rd,
  output logic [1:0]       alu_op,
  output logic             end_flag
);

  logic       srst_n;
  seq_state_e state;
  seq_state_e state_nxt;

  ctrl_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ctrl_seq_next #(.N_INS(N_INS), .ADD_LINE(ADD_LINE)) u_next (
    .cur      (state),
    .mem_done (mem_done),
    .ins_line (ins_line),
    .nxt      (state_nxt)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state <= ST_F_ADDR;
    else         state <= state_nxt;
  end

  ctrl_seq_out u_out (
    .cur      (state),
    .live     (srst_n),
    .drv_en   (drv_en),
    .ld_en    (ld_en),
    .mem_rd   (mem_rd),
    .alu_op   (alu_op),
    .end_flag (end_flag)
  );

  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_F_WAIT && !mem_done) |=> (state == ST_F_WAIT && $stable(drv_en) && $stable(ld_en)));

  assert_one_driver_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(drv_en));

  assert_end_to_fetch_R8: assert property (@(posedge clk) disable iff (!srst_n)
    end_flag |=> (state == ST_F_ADDR));

  assert_r1_write_ends_R8: assert property (@(posedge clk) disable iff (!srst_n)
    ld_en[RG_R1] |-> end_flag);

  assert_no_exec_without_line_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_DEC && !ins_line[ADD_LINE]) |=> (state == ST_NOP_END));

  assert_read_loads_mar_R7: assert property (@(posedge clk) disable iff (!srst_n)
    mem_rd |-> ld_en[RG_MAR]);

endmodule

// File: tb/sim_ctrl_seq.sv
module sim_ctrl_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mem_done;
  logic [3:0] ins_line;
  logic [6:0] drv_en, ld_en;
  logic       mem_rd, end_flag;
  logic [1:0] alu_op;

  int n_chk = 0;
  int n_fail = 0;
  int step;
  int wcnt;
  int kind;
  logic [15:0] m_pc, m_mar, m_mdr, m_ir, m_y, m_z, m_r1;
  logic [15:0] pc0, r1_0, exp_r1;

  always #5 clk = ~clk;

  ctrl_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_done(mem_done), .ins_line(ins_line),
    .drv_en(drv_en), .ld_en(ld_en), .mem_rd(mem_rd), .alu_op(alu_op), .end_flag(end_flag)
  );

  function automatic logic [15:0] mem_word(logic [7:0] a);
    return (16'(a) * 16'd97 + 16'd13) ^ (16'(a) << 9);
  endfunction

  // {drv[6:0], ld[6:0], rd, alu[1:0], fin}
  function automatic logic [17:0] exp_word(int s);
    case (s)
      0:  return {7'h01, 7'h22, 1'b1, 2'd2, 1'b0};
      1:  return {7'h20, 7'h01, 1'b0, 2'd0, 1'b0};
      3:  return {7'h04, 7'h08, 1'b0, 2'd0, 1'b0};
      5:  return {7'h08, 7'h02, 1'b1, 2'd0, 1'b0};
      7:  return {7'h40, 7'h10, 1'b0, 2'd0, 1'b0};
      8:  return {7'h04, 7'h20, 1'b0, 2'd1, 1'b0};
      9:  return {7'h20, 7'h40, 1'b0, 2'd0, 1'b1};
      10: return {7'h00, 7'h00, 1'b0, 2'd0, 1'b1};
      default: return 18'd0;
    endcase
  endfunction

  function automatic int next_step(int s, logic md, logic [3:0] ins);
    case (s)
      2: return md ? 3 : 2;
      4: return ins[0] ? 5 : 10;
      6: return md ? 7 : 6;
      9, 10: return 0;
      default: return s + 1;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 10: return "R6";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] dut_word();
    return {drv_en, ld_en, mem_rd, alu_op, end_flag};
  endfunction

  // One cycle: check at the falling edge, drive inputs, advance the models.
  task automatic cycle(input logic md, input logic [3:0] ins);
    logic [15:0] bus, n_mar, n_mdr;
    chk(dut_word() == exp_word(step), tag_of(step), 32'(dut_word()), 32'(exp_word(step)));
    chk($countones(drv_en) <= 1, "R9", 32'(drv_en), 32'h0);
    mem_done = md;
    ins_line = ins;
    bus = 16'h0;
    if (drv_en[0]) bus = m_pc;
    if (drv_en[2]) bus = m_mdr;
    if (drv_en[3]) bus = {8'h00, m_ir[7:0]};
    if (drv_en[4]) bus = m_y;
    if (drv_en[5]) bus = m_z;
    if (drv_en[6]) bus = m_r1;
    n_mar = ld_en[1] ? bus : m_mar;
    n_mdr = md ? mem_word(m_mar[7:0]) : m_mdr;
    if (ld_en[5]) m_z = (alu_op == 2'd2) ? bus + 16'd1 : (alu_op == 2'd1) ? m_y + bus : bus;
    if (ld_en[0]) m_pc = bus;
    if (ld_en[3]) m_ir = bus;
    if (ld_en[4]) m_y = bus;
    if (ld_en[6]) m_r1 = bus;
    m_mar = n_mar;
    m_mdr = n_mdr;
    step = next_step(step, md, ins);
    @(negedge clk);
  endtask

  task automatic do_reset(input int low_cycles);
    rst_n = 1'b0;
    for (int i = 0; i < low_cycles; i++) begin
      mem_done = 1'($urandom);
      @(negedge clk);
      chk(dut_word() == 18'd0, "R1", 32'(dut_word()), 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(dut_word() == 18'd0, "R1", 32'(dut_word()), 32'h0);
    @(negedge clk);
    chk(dut_word() == exp_word(0), "R1", 32'(dut_word()), 32'(exp_word(0)));
    step = 0;
  endtask

  task automatic run_instr(input int k, input int w1, input int w2);
    logic [3:0] dec_ins;
    logic       md;
    pc0  = m_pc;
    r1_0 = m_r1;
    exp_r1 = r1_0 + mem_word(mem_word(pc0[7:0])[7:0]);
    case (k)
      0: dec_ins = 4'(($urandom & 32'he)) | 4'h1;
      1: dec_ins = 4'(1 << (1 + ($urandom % 3)));
      default: dec_ins = 4'h0;
    endcase
    wcnt = w1;
    do begin
      if (step == 2 || step == 6) begin
        md = (wcnt == 0);
        if (wcnt > 0) wcnt--;
      end else begin
        md = 1'($urandom);
      end
      if (step == 4) begin
        cycle(md, dec_ins);
        if (step == 5) wcnt = w2;
      end else begin
        cycle(md, 4'($urandom));
      end
    end while (step != 0);
    chk(m_pc == pc0 + 16'd1, "R10", 32'(m_pc), 32'(pc0 + 16'd1));
    if (k == 0) chk(m_r1 == exp_r1, "R10", 32'(m_r1), 32'(exp_r1));
    else        chk(m_r1 == r1_0, "R6", 32'(m_r1), 32'(r1_0));
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; mem_done = 1'b0; ins_line = 4'h0; step = 0;
    m_pc = 16'h0; m_mar = 16'h0; m_mdr = 16'h0; m_ir = 16'h0;
    m_y = 16'h0; m_z = 16'h0; m_r1 = 16'd5;
    @(negedge clk);
    do_reset(3);
    // directed: add with no wait, add with long waits, undecoded, other line
    run_instr(0, 0, 0);
    run_instr(0, 20, 17);
    run_instr(2, 1, 0);
    run_instr(1, 0, 0);
    for (int i = 0; i < 300; i++) begin
      kind = int'($urandom % 10);
      run_instr(kind < 6 ? 0 : (kind < 8 ? 1 : 2), int'($urandom % 5), int'($urandom % 5));
      if (i == 150) do_reset(2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", step, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule